// File: doc/BRIEF.md
# Edge-Counting Response Bit Receiver

This block recovers a short answer frame sent from a contactless card back to a reader. The card answers by switching a subcarrier on or off for whole bit periods, and the digitised receive line then either toggles rapidly or stays quiet. After an arm strobe, the receiver waits a fixed turnaround time. It then cuts the line into back-to-back bit windows of equal length and counts the level changes in each window. A window with more changes than a threshold carries a one.

The received word is decrypted on the fly. It is preloaded with a keystream word supplied at arm time, and each busy window toggles its own bit position, so the result is the keystream XOR the raw bits. All timing runs on a tick-enable input, so the durations are independent of the system clock.

A second mode serves write acknowledges. After a longer wait, the block scans a bounded number of windows for the first busy one. It reports whether an acknowledge arrived and how many whole bit periods passed between the arm strobe and the end of that window.

Top module: `resp_bit_rx`

## Requirements
- R1: In frame mode the first bit window begins TURN_TICKS ticks after the arm strobe (default 477). A frame of length 0 completes at the end of the turnaround and returns the keystream unchanged.
- R2: Each bit window lasts WINDOW_TICKS ticks (default 142), with no gap between windows. `done_o` is a single-cycle pulse in the cycle after the tick that ends the last window.
- R3: Every clock cycle inside a window in which `line_i` differs from its value in the previous cycle adds one to that window's edge count. The count saturates at 2^EDGE_W-1 and does not wrap.
- R4: A window is a one when its edge count is strictly greater than EDGE_THRESH (default 20). A count equal to the threshold leaves the bit as it was.
- R5: `word_o` is loaded with `key_i` at arm time. Window i of the frame XORs a one into bit i, starting at bit 0 (least significant bit first).
- R6: Arming in frame mode with `nbits_i` greater than MAX_BITS (32) receives nothing. `reject_o` pulses for one cycle, in the cycle after the strobe, and no `done_o` follows.
- R7: With `ack_mode_i` high at arm time, the block waits ACK_WAIT_TICKS ticks (default 5400) and then scans up to ACK_WINDOWS windows (default 40). At the end of the first busy window it pulses `done_o` with `ack_ok_o` = 1.
- R8: On a successful acknowledge, `ack_periods_o` equals the number of ticks from the arm strobe to the end of the busy window, divided by WINDOW_TICKS and rounded down.
- R9: If no scanned window is busy, `done_o` pulses at the end of the last window with `ack_ok_o` = 0. In frame mode `ack_ok_o` is 0 at `done_o`.
- R10: An arm strobe while a reception is in progress is ignored. The running result and its completion time are unchanged.
- R11: Turnaround, wait and window durations advance only on cycles with `tick_i` high. Edges are counted on every clock cycle.
- R12: After reset, `done_o`, `reject_o` and `ack_ok_o` are low and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start strobe, honoured only when idle |
| ack_mode_i | input | 1 | 1: acknowledge search, 0: frame reception |
| nbits_i | input | clog2(MAX_BITS+1) | Frame length in bits |
| key_i | input | MAX_BITS | Keystream word preloaded into the result |
| tick_i | input | 1 | Time-base enable, one tick per high cycle |
| line_i | input | 1 | Digitised receive line, synchronous to clk |
| done_o | output | 1 | One-cycle pulse, result valid |
| reject_o | output | 1 | One-cycle pulse, frame length too large |
| word_o | output | MAX_BITS | Received, decrypted word |
| ack_ok_o | output | 1 | Acknowledge found (acknowledge mode) |
| ack_periods_o | output | PER_W | Whole bit periods from arm to acknowledge |

## Verification
The bench shrinks the timing to a 20-tick turnaround, 16-tick windows, a 30-tick acknowledge wait and a 5-window scan. It lowers the threshold to 4 and narrows the edge counter to 3 bits, so frames of all 32 bits and acknowledge failures stay short. With these values, windows holding exactly 4 and 5 edges sit on both sides of the threshold. A window holding 12 edges tells saturation apart from wrap, because a wrapped 3-bit count would read 4 and lose the bit. The frame width stays at 32, so the over-length rejection at 33 bits and the use of every bit position are both exercised. The tick enable is also driven at a slower rate to show that only ticks set the completion cycle.

// File: rtl/resp_rx_pkg.sv
package resp_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_TURN     = 3'd1,
        ST_BITS     = 3'd2,
        ST_ACK_WAIT = 3'd3,
        ST_ACK_SCAN = 3'd4
    } rx_state_t;

    function automatic logic in_window(input rx_state_t s);
        return (s == ST_BITS) || (s == ST_ACK_SCAN);
    endfunction

endpackage

// File: rtl/resp_rx_tick_timer.sv
module resp_rx_tick_timer #(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = tick_i && (cnt_q == limit_i - TW'(1));
        cnt_d    = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = expire_o ? '0 : cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/resp_rx_edge_counter.sv
module resp_rx_edge_counter #(
    parameter int EDGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic              line_i,
    output logic [EDGE_W-1:0] count_o,
    output logic [EDGE_W-1:0] count_next_o
);
    localparam logic [EDGE_W-1:0] SAT = {EDGE_W{1'b1}};

    logic              line_q;
    logic [EDGE_W-1:0] cnt_d, cnt_q;
    logic              toggled;

    always_comb begin
        toggled      = (line_i != line_q);
        count_next_o = cnt_q;
        if (en_i && toggled && (cnt_q != SAT)) begin
            count_next_o = cnt_q + EDGE_W'(1);
        end
        cnt_d = clear_i ? '0 : count_next_o;
    end

    assign count_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            line_q <= line_i;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/resp_rx_period_counter.sv
module resp_rx_period_counter #(
    parameter int WINDOW_TICKS = 142,
    parameter int PER_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    output logic [PER_W-1:0] periods_next_o
);
    localparam int SW = $clog2(WINDOW_TICKS + 1);

    logic [SW-1:0]    sub_d, sub_q;
    logic [PER_W-1:0] per_d, per_q;
    logic             wrap;

    always_comb begin
        wrap           = tick_i && (sub_q == SW'(WINDOW_TICKS - 1));
        periods_next_o = wrap ? per_q + PER_W'(1) : per_q;
        sub_d          = sub_q;
        if (tick_i) sub_d = wrap ? '0 : sub_q + SW'(1);
        per_d = periods_next_o;
        if (clear_i) begin
            sub_d = '0;
            per_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            per_q <= '0;
        end else begin
            sub_q <= sub_d;
            per_q <= per_d;
        end
    end
endmodule

// File: rtl/resp_bit_rx.sv
module resp_bit_rx
    import resp_rx_pkg::*;
#(
    parameter int MAX_BITS       = 32,
    parameter int TURN_TICKS     = 477,
    parameter int WINDOW_TICKS   = 142,
    parameter int ACK_WAIT_TICKS = 5400,
    parameter int ACK_WINDOWS    = 40,
    parameter int EDGE_THRESH    = 20,
    parameter int EDGE_W         = 6,
    parameter int PER_W          = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              arm_i,
    input  logic                              ack_mode_i,
    input  logic [$clog2(MAX_BITS+1)-1:0]     nbits_i,
    input  logic [MAX_BITS-1:0]               key_i,
    input  logic                              tick_i,
    input  logic                              line_i,
    output logic                              done_o,
    output logic                              reject_o,
    output logic [MAX_BITS-1:0]               word_o,
    output logic                              ack_ok_o,
    output logic [PER_W-1:0]                  ack_periods_o
);
    localparam int NBW     = $clog2(MAX_BITS + 1);
    localparam int AWW     = $clog2(ACK_WINDOWS);
    localparam int IW      = (NBW > AWW) ? NBW : AWW;
    localparam int MAX_T1  = (TURN_TICKS > WINDOW_TICKS) ? TURN_TICKS : WINDOW_TICKS;
    localparam int MAX_T   = (MAX_T1 > ACK_WAIT_TICKS) ? MAX_T1 : ACK_WAIT_TICKS;
    localparam int TW      = $clog2(MAX_T + 1);
    localparam logic [EDGE_W-1:0] THR = EDGE_W'(EDGE_THRESH);
    localparam logic [MAX_BITS-1:0] ONE_HOT0 = MAX_BITS'(1);

    typedef struct packed {
        rx_state_t          state;
        logic [IW-1:0]      idx;
        logic [IW-1:0]      nbits;
        logic               ack_mode;
        logic [MAX_BITS-1:0] word;
        logic               done;
        logic               reject;
        logic               ack_ok;
        logic [PER_W-1:0]   periods;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic              busy;
    logic              win_active;
    logic              timer_expire;
    logic [TW-1:0]     timer_limit;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_cnt_next;
    logic [PER_W-1:0]  periods_next;
    logic              win_end;
    logic              busy_bit;

    assign busy       = (r_q.state != ST_IDLE);
    assign win_active = in_window(r_q.state);
    assign win_end    = win_active && timer_expire;
    assign busy_bit   = (edge_cnt_next > THR);

    always_comb begin
        case (r_q.state)
            ST_TURN:     timer_limit = TW'(TURN_TICKS);
            ST_ACK_WAIT: timer_limit = TW'(ACK_WAIT_TICKS);
            default:     timer_limit = TW'(WINDOW_TICKS);
        endcase
    end

    resp_rx_tick_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (!busy),
        .tick_i   (tick_i && busy),
        .limit_i  (timer_limit),
        .expire_o (timer_expire)
    );

    resp_rx_edge_counter #(.EDGE_W(EDGE_W)) u_edges (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (!win_active || win_end),
        .en_i         (win_active),
        .line_i       (line_i),
        .count_o      (edge_cnt),
        .count_next_o (edge_cnt_next)
    );

    resp_rx_period_counter #(.WINDOW_TICKS(WINDOW_TICKS), .PER_W(PER_W)) u_periods (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (!busy),
        .tick_i         (tick_i && busy),
        .periods_next_o (periods_next)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.reject = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (arm_i) begin
                    if (!ack_mode_i && (nbits_i > NBW'(MAX_BITS))) begin
                        r_d.reject = 1'b1;
                    end else begin
                        r_d.word     = key_i;
                        r_d.nbits    = IW'(nbits_i);
                        r_d.ack_mode = ack_mode_i;
                        r_d.idx      = '0;
                        r_d.ack_ok   = 1'b0;
                        r_d.periods  = '0;
                        r_d.state    = ack_mode_i ? ST_ACK_WAIT : ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                if (timer_expire) begin
                    if (r_q.nbits == '0) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_BITS;
                    end
                end
            end
            ST_BITS: begin
                if (timer_expire) begin
                    if (busy_bit) r_d.word = r_q.word ^ (ONE_HOT0 << r_q.idx);
                    if (r_q.idx == r_q.nbits - IW'(1)) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + IW'(1);
                    end
                end
            end
            ST_ACK_WAIT: begin
                if (timer_expire) begin
                    r_d.idx   = '0;
                    r_d.state = ST_ACK_SCAN;
                end
            end
            ST_ACK_SCAN: begin
                if (timer_expire) begin
                    if (busy_bit || (r_q.idx == IW'(ACK_WINDOWS - 1))) begin
                        r_d.ack_ok  = busy_bit;
                        r_d.periods = periods_next;
                        r_d.done    = 1'b1;
                        r_d.state   = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + IW'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.idx      <= '0;
            r_q.nbits    <= '0;
            r_q.ack_mode <= 1'b0;
            r_q.word     <= '0;
            r_q.done     <= 1'b0;
            r_q.reject   <= 1'b0;
            r_q.ack_ok   <= 1'b0;
            r_q.periods  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o        = r_q.done;
    assign reject_o      = r_q.reject;
    assign word_o        = r_q.word;
    assign ack_ok_o      = r_q.ack_ok;
    assign ack_periods_o = r_q.periods;

    rx_state_t cur_state;
    logic      cur_ack_mode;
    assign cur_state    = r_q.state;
    assign cur_ack_mode = r_q.ack_mode;
endmodule

// File: rtl/resp_bit_rx_chk.sv
module resp_bit_rx_chk
    import resp_rx_pkg::*;
#(
    parameter int EDGE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              done_o,
    input logic              reject_o,
    input logic              ack_ok_o,
    input rx_state_t         state,
    input logic              ack_mode,
    input logic [EDGE_W-1:0] edge_cnt,
    input logic              win_end
);
    localparam logic [EDGE_W-1:0] SAT = {EDGE_W{1'b1}};

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_reject_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> (!done_o && state == ST_IDLE));

    p_edge_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window(state) && edge_cnt == SAT && !win_end) |=> (edge_cnt == SAT));

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !tick_i) |=> $stable(state));

    p_turn_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN || state == ST_ACK_WAIT) |-> (edge_cnt == '0));

    p_frame_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ack_mode) |-> !ack_ok_o);
endmodule

bind resp_bit_rx resp_bit_rx_chk #(.EDGE_W(EDGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .done_o   (done_o),
    .reject_o (reject_o),
    .ack_ok_o (ack_ok_o),
    .state    (cur_state),
    .ack_mode (cur_ack_mode),
    .edge_cnt (edge_cnt),
    .win_end  (win_end)
);

// File: tb/resp_bit_rx_bench.sv
module resp_bit_rx_bench;
    localparam int MAXB = 32;
    localparam int TURN = 20;
    localparam int WIN  = 16;
    localparam int AWT  = 30;
    localparam int AWN  = 5;
    localparam int THR  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        ack_mode_i = 1'b0;
    logic [5:0]  nbits_i = '0;
    logic [31:0] key_i = '0;
    logic        tick_i = 1'b0;
    logic        line_i = 1'b0;
    logic        done_o, reject_o, ack_ok_o;
    logic [31:0] word_o;
    logic [15:0] ack_periods_o;

    resp_bit_rx #(
        .MAX_BITS(MAXB), .TURN_TICKS(TURN), .WINDOW_TICKS(WIN),
        .ACK_WAIT_TICKS(AWT), .ACK_WINDOWS(AWN), .EDGE_THRESH(THR),
        .EDGE_W(3), .PER_W(16)
    ) u_resp_bit_rx (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .ack_mode_i(ack_mode_i),
        .nbits_i(nbits_i), .key_i(key_i), .tick_i(tick_i), .line_i(line_i),
        .done_o(done_o), .reject_o(reject_o), .word_o(word_o),
        .ack_ok_o(ack_ok_o), .ack_periods_o(ack_periods_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        bit          ack;
        logic [31:0] word;
        bit          ok;
        int          periods;
        int          at;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // monitor: compare each completion against the next expected item
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.at, {e.tag, " completion cycle"}, cyc, e.at);
                if (!e.ack) begin
                    check(word_o == e.word, {e.tag, " word"}, word_o, e.word);
                    check(ack_ok_o == 1'b0, "R9 ack flag in frame mode", ack_ok_o, 0);
                end else begin
                    check(ack_ok_o == e.ok, {e.tag, " ack flag"}, ack_ok_o, e.ok);
                    if (e.ok)
                        check(ack_periods_o == 16'(e.periods), "R8 ack periods",
                              ack_periods_o, e.periods);
                end
            end
        end
    end

    int tog[0:39];

    // drive one reception; tog[] holds the edge count per window
    task automatic run(input bit ack, input int nbits, input logic [31:0] key,
                       input int step, input int stray_arm, input string tag);
        exp_t e;
        int   nwin, base, dur, first;
        logic [31:0] w;
        nwin  = ack ? AWN : nbits;
        base  = (ack ? AWT : TURN) * step;
        w     = key;
        first = -1;
        for (int i = 0; i < nwin; i++) begin
            if (tog[i] > THR) begin
                if (!ack) w[i] = ~w[i];
                else if (first < 0) first = i;
            end
        end
        if (!ack) dur = base + nbits * WIN * step;
        else if (first >= 0) dur = base + (first + 1) * WIN * step;
        else dur = base + AWN * WIN * step;
        e.ack = ack; e.word = w; e.ok = (first >= 0);
        e.periods = (first >= 0) ? (AWT + (first + 1) * WIN) / WIN : 0;
        e.tag = tag;
        @(negedge clk);
        e.at = cyc + 1 + dur;
        exp_q.push_back(e);
        arm_i = 1'b1; ack_mode_i = ack; nbits_i = 6'(nbits); key_i = key; tick_i = 1'b0;
        for (int m = 1; m <= dur; m++) begin
            @(negedge clk);
            arm_i  = (m == stray_arm);
            key_i  = (m == stray_arm) ? ~key : key;
            tick_i = (m % step == 0);
            if (m > base) begin
                int r, wi, j;
                r  = m - 1 - base;
                wi = r / (WIN * step);
                j  = r % (WIN * step);
                if (wi < nwin && j >= 2 && j < 2 + tog[wi]) line_i = ~line_i;
            end
        end
        @(negedge clk);
        arm_i = 1'b0; tick_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_tog();
        for (int i = 0; i < 40; i++) tog[i] = 0;
    endtask

    bit wd_fired = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        wd_fired = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R12 reset state
                check(done_o == 1'b0,   "R12 done after reset", done_o, 0);
                check(reject_o == 1'b0, "R12 reject after reset", reject_o, 0);
                check(ack_ok_o == 1'b0, "R12 ack flag after reset", ack_ok_o, 0);
                check(word_o == 32'h0,  "R12 word after reset", word_o, 0);

                // R1 R2 R5: 12-bit frame, alternating busy windows
                clear_tog();
                for (int i = 0; i < 12; i++) tog[i] = (i % 2 == 0) ? 8 : 0;
                run(1'b0, 12, 32'h0000_0A5C, 1, 0, "R5 alternating frame");

                // R4: threshold edge counts 4 (kept) and 5 (flipped)
                clear_tog();
                tog[0] = 4; tog[1] = 5; tog[2] = 0; tog[3] = 4; tog[4] = 5; tog[5] = 3;
                run(1'b0, 6, 32'h0000_0015, 1, 0, "R4 threshold frame");

                // R3: 12 edges must saturate, not wrap to 4
                clear_tog();
                tog[0] = 12; tog[2] = 12;
                run(1'b0, 3, 32'h0000_0000, 1, 0, "R3 saturation frame");

                // R5: full-width frame
                clear_tog();
                for (int i = 0; i < 32; i++) tog[i] = (i % 3 == 0) ? 8 : 1;
                run(1'b0, 32, 32'hDEAD_BEEF, 1, 0, "R5 full-width frame");

                // R11: one tick every third clock
                clear_tog();
                tog[1] = 9; tog[4] = 7;
                run(1'b0, 5, 32'h0000_0003, 3, 0, "R11 slow tick frame");

                // R1: zero-length frame returns key
                clear_tog();
                run(1'b0, 0, 32'h1234_5678, 1, 0, "R1 empty frame");

                // R10: stray arm in mid frame
                clear_tog();
                tog[0] = 8; tog[7] = 8;
                run(1'b0, 8, 32'h0000_00F0, 1, 50, "R10 stray arm frame");

                // R6: oversize frame rejected
                @(negedge clk);
                arm_i = 1'b1; ack_mode_i = 1'b0; nbits_i = 6'd33; tick_i = 1'b1;
                @(negedge clk);
                arm_i = 1'b0;
                check(reject_o == 1'b1, "R6 reject pulse", reject_o, 1);
                check(done_o == 1'b0,   "R6 no done with reject", done_o, 0);
                @(negedge clk);
                check(reject_o == 1'b0, "R6 reject one cycle", reject_o, 0);
                repeat (60) @(negedge clk);
                tick_i = 1'b0;
                check(exp_q.size() == 0, "R6 nothing pending", exp_q.size(), 0);

                // R7 R8: acknowledge in third window
                clear_tog();
                tog[0] = 4; tog[2] = 8;
                run(1'b1, 0, 32'h0, 1, 0, "R7 ack third window");

                // R8: acknowledge in first window
                clear_tog();
                tog[0] = 6;
                run(1'b1, 0, 32'h0, 1, 0, "R8 ack first window");

                // R9: no acknowledge
                clear_tog();
                tog[1] = 3;
                run(1'b1, 0, 32'h0, 1, 0, "R9 ack missing");

                // R8 R11: acknowledge in last window, slow tick
                clear_tog();
                tog[4] = 10;
                run(1'b1, 0, 32'h0, 2, 0, "R8 ack last window slow tick");

                check(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 0);
            end
            begin
                wait (wd_fired);
            end
        join_any
        if (wd_fired) check(1'b0, "watchdog expired", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule